// File: doc/BRIEF.md
# Stereo Serial-Audio Transmitter with Pair FIFO

This block sends stereo audio on a three-wire serial link: a bit clock, a word-select line and a data line. The host pushes complete left/right sample pairs into an eight-deep FIFO through a valid/ready port. Two holding registers, one for each channel, sit between the FIFO and a single shift register. Each word is parallel-loaded into the shift register and sent MSB first. The bit clock is divided down from the system clock by a programmable half-period count.

When the FIFO runs dry, the transmitter does not stop. It sends the last pair in the holding registers again, frame after frame, and raises a sticky underflow flag. After reset the holding registers hold zero, so the first frame after enabling is silence. The host reads a five-bit flag vector that gives FIFO occupancy and the two sticky error conditions. The bit-clock divider setting is taken only while the channel is disabled. Disabling stops the link and clears both sticky flags. It keeps the FIFO contents and the holding registers.

Top module: `stereo_ser_tx`

## Requirements
- R1: After reset, `flags` reads 5'b01100 (empty and half-empty set, all others clear), `wr_ready` is 1, and `sclk`, `ws` and `sd` are 0.
- R2: The FIFO holds at most 8 pairs. `flags[4]` (full) is 1 exactly when 8 pairs are stored, and `wr_ready` is its inverse.
- R3: `flags[3]` (half-empty) is 1 while 4 or fewer pairs are stored. `flags[2]` (empty) is 1 while no pair is stored.
- R4: A write with `wr_valid` high while full sets the sticky `flags[1]` (overflow). The pair is dropped and never transmitted.
- R5: `ws` and `sd` change only when `sclk` falls, and a receiver samples them on the rising edge. `ws` is 0 during the left word and 1 during the right word. Each word is WORD_W bits, MSB first, and its MSB follows the `ws` change by one bit.
- R6: On enable, the first left and right words come from the holding registers without a FIFO read. After reset both registers hold zero.
- R7: The FIFO is read only in the cycle the right holding register is loaded into the shift register. The pair read goes out in the next frame, and pairs leave in write order.
- R8: If that read finds the FIFO empty, `flags[0]` (underflow) is set, nothing is read, and the holding registers are sent again.
- R9: An accepted write clears `flags[0]`. If the write lands in the same cycle as a read that finds the FIFO empty, the flag stays 0 and the new pair is read at the next frame boundary.
- R10: Disabling clears `flags[0]` and `flags[1]` and drives `sclk`, `ws` and `sd` to 0. It keeps the FIFO and the holding registers, so a re-enable first repeats the last pair sent.
- R11: `cfg_half_div` is sampled only while `enable` is 0. Each `sclk` half period lasts `cfg_half_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel enable |
| cfg_half_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| wr_valid | input | 1 | Host offers a sample pair |
| wr_left | input | WORD_W | Left sample of the pair |
| wr_right | input | WORD_W | Right sample of the pair |
| wr_ready | output | 1 | FIFO can accept a pair |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| flags | output | 5 | {full, half-empty, empty, overflow, underflow} |

## Verification
The case that matters is a host write that lands in the same cycle as a frame-boundary read of an empty FIFO. In that cycle the underflow set and the write-driven clear compete. The bench watches the bit-clock rising edge that comes just before the left-to-right boundary. From it the bench computes the system-clock edge where the right word loads, and it presents a pair exactly on that edge. The outcome is judged at the ports. The underflow flag must stay clear, and the decoded serial stream must show one more frame of the holding-register contents followed by the new pair.

// File: rtl/stx_pkg.sv
package stx_pkg;
    // Bit positions inside the flag vector.
    localparam int FLG_UNDER = 0;
    localparam int FLG_OVER  = 1;
    localparam int FLG_EMPTY = 2;
    localparam int FLG_HALF  = 3;
    localparam int FLG_FULL  = 4;
    localparam int FLG_W     = 5;
endpackage

// File: rtl/stx_pair_fifo.sv
module stx_pair_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_req,
    input  logic [DATA_W-1:0]   push_left,
    input  logic [DATA_W-1:0]   push_right,
    input  logic                pop_req,
    output logic                push_ok,
    output logic                pop_ok,
    output logic [DATA_W-1:0]   head_left,
    output logic [DATA_W-1:0]   head_right,
    output logic                full,
    output logic                empty,
    output logic                half_empty
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int PAIR_W = 2 * DATA_W;

    typedef struct packed {
        logic [DEPTH-1:0][PAIR_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    assign full       = (st_q.cnt == CNT_W'(DEPTH));
    assign empty      = (st_q.cnt == '0);
    assign half_empty = (st_q.cnt <= CNT_W'(DEPTH / 2));
    assign push_ok    = push_req && !full;
    assign pop_ok     = pop_req && !empty;
    assign head_left  = st_q.mem[st_q.rp][PAIR_W-1:DATA_W];
    assign head_right = st_q.mem[st_q.rp][DATA_W-1:0];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_ok) begin
            st_d.mem[st_q.wp] = {push_left, push_right};
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop_ok) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'($past(pop_ok))));

    // R2
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (st_q.cnt <= CNT_W'(DEPTH)));
endmodule

// File: rtl/stx_bitclk.sv
module stx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             fall_evt
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic             started;
    } clk_st_t;

    clk_st_t st_q, st_d;
    logic    tick;

    assign tick     = en && (st_q.cnt == half_div);
    // The first tick after enabling is a falling-type event with sclk held low.
    assign fall_evt = tick && (!st_q.started || st_q.sclk);
    assign sclk     = st_q.sclk;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt = '0;
            if (!st_q.started) begin
                st_d.started = 1'b1;
            end else begin
                st_d.sclk = ~st_q.sclk;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk);

    // R11
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(sclk));
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall_evt,
    input  logic [WORD_W-1:0] hold_left,
    input  logic [WORD_W-1:0] hold_right,
    output logic              ws,
    output logic              sd,
    output logic              need_pair
);
    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [BIT_W-1:0]  bitn;
        logic              side;
        logic              ws;
        logic              sd;
    } sh_st_t;

    sh_st_t st_q, st_d;
    logic   slot_start;

    assign slot_start = en && fall_evt && (st_q.bitn == '0);
    assign need_pair  = slot_start && st_q.side;
    assign ws         = st_q.ws;
    assign sd         = st_q.sd;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (fall_evt) begin
            st_d.ws = st_q.side;
            st_d.sd = st_q.sh[WORD_W-1];
            if (slot_start) begin
                st_d.sh = st_q.side ? hold_right : hold_left;
            end else begin
                st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
            end
            if (st_q.bitn == BIT_W'(WORD_W - 1)) begin
                st_d.bitn = '0;
                st_d.side = ~st_q.side;
            end else begin
                st_d.bitn = st_q.bitn + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fall_evt) |=> $stable(ws));

    // R5
    sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !fall_evt) |=> $stable(sd));
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
    parameter int WORD_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_left,
    input  logic [WORD_W-1:0] wr_right,
    output logic              wr_ready,
    output logic              sclk,
    output logic              ws,
    output logic              sd,
    output logic [4:0]        flags
);
    import stx_pkg::*;

    typedef struct packed {
        logic              en_prev;
        logic [DIV_W-1:0]  div;
        logic [WORD_W-1:0] hold_l;
        logic [WORD_W-1:0] hold_r;
        logic              under;
        logic              over;
    } top_st_t;

    top_st_t st_q, st_d;

    logic              push_ok, pop_ok;
    logic              fifo_full, fifo_empty, fifo_half;
    logic [WORD_W-1:0] head_l, head_r;
    logic              fall_evt, need_pair;
    logic              dis_fall;

    assign dis_fall = st_q.en_prev && !enable;

    stx_pair_fifo #(
        .DATA_W (WORD_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (wr_valid),
        .push_left  (wr_left),
        .push_right (wr_right),
        .pop_req    (need_pair),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .head_left  (head_l),
        .head_right (head_r),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .half_empty (fifo_half)
    );

    stx_bitclk #(
        .DIV_W (DIV_W)
    ) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (enable),
        .half_div (st_q.div),
        .sclk     (sclk),
        .fall_evt (fall_evt)
    );

    stx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .fall_evt   (fall_evt),
        .hold_left  (st_q.hold_l),
        .hold_right (st_q.hold_r),
        .ws         (ws),
        .sd         (sd),
        .need_pair  (need_pair)
    );

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = enable;
        if (!enable) begin
            st_d.div = cfg_half_div;
        end
        if (pop_ok) begin
            st_d.hold_l = head_l;
            st_d.hold_r = head_r;
        end
        // Clearing has priority over setting for both sticky flags.
        if (dis_fall || push_ok) begin
            st_d.under = 1'b0;
        end else if (need_pair && fifo_empty) begin
            st_d.under = 1'b1;
        end
        if (dis_fall) begin
            st_d.over = 1'b0;
        end else if (wr_valid && fifo_full) begin
            st_d.over = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ready         = !fifo_full;
    assign flags[FLG_UNDER] = st_q.under;
    assign flags[FLG_OVER]  = st_q.over;
    assign flags[FLG_EMPTY] = fifo_empty;
    assign flags[FLG_HALF]  = fifo_half;
    assign flags[FLG_FULL]  = fifo_full;

    // R8
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_pair && !wr_ready && 1'b0) || (need_pair && flags[FLG_EMPTY] && !wr_valid)
        |=> flags[FLG_UNDER]);

    // R9
    write_clears_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !flags[FLG_UNDER]);

    // R4
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && enable) |=> flags[FLG_OVER]);

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en_prev && !enable) |=> (!flags[FLG_UNDER] && !flags[FLG_OVER]));

    // R7
    no_idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !need_pair |=> ($stable(st_q.hold_l) && $stable(st_q.hold_r)));
endmodule

// File: tb/sim_stereo_ser_tx.sv
`timescale 1ns/1ps
module sim_stereo_ser_tx;
    localparam int W  = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic [DW-1:0] cfg_half_div;
    logic          wr_valid;
    logic [W-1:0]  wr_left, wr_right;
    logic          wr_ready, sclk, ws, sd;
    logic [4:0]    flags;

    int n_chk = 0;
    int n_err = 0;
    int ws_bad;
    bit done = 1'b0;
    logic [W-1:0] got [0:31];
    logic [W-1:0] exp_w [0:31];

    always #5 clk = ~clk;

    stereo_ser_tx #(.WORD_W(W), .FIFO_DEPTH(8), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_half_div(cfg_half_div),
        .wr_valid(wr_valid), .wr_left(wr_left), .wr_right(wr_right),
        .wr_ready(wr_ready), .sclk(sclk), .ws(ws), .sd(sd), .flags(flags)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [W-1:0] smp(input int i, input bit right);
        return W'((i + 1) * 32'h1357 ^ (right ? 32'h9A3C : 32'h6C5A));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; wr_valid = 1'b0;
        wr_left = '0; wr_right = '0; cfg_half_div = DW'(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        @(negedge clk);
        wr_valid = 1'b1; wr_left = l; wr_right = r;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Decodes n words from the serial line, counting sclk rises from enable.
    task automatic collect(input int n);
        logic [W-2:0] acc = '0;
        ws_bad = 0;
        for (int r = 0; r <= n * W; r++) begin
            @(posedge sclk);
            #1;
            if (ws !== 1'(((r / W) % 2))) ws_bad++;
            if ((r % W) == 0) begin
                if (r > 0) got[r / W - 1] = {acc, sd};
                acc = '0;
            end else begin
                acc = {acc[W-3:0], sd};
            end
        end
    endtask

    task automatic cmp_words(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            chk(got[k] === exp_w[k], req, 64'(got[k]), 64'(exp_w[k]));
        end
        chk(ws_bad == 0, "R5 ws framing", 64'(ws_bad), 64'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(flags === 5'b01100, "R1 flags", 64'(flags), 64'h0c);
        chk(wr_ready === 1'b1, "R1 wr_ready", 64'(wr_ready), 64'd1);
        chk({sclk, ws, sd} === 3'b000, "R1 serial idle", 64'({sclk, ws, sd}), 64'd0);
    endtask

    task automatic t_fill_drain();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            wr_pair(smp(i, 0), smp(i, 1));
            chk(flags[3] === (i < 4), "R3 half-empty", 64'(flags[3]), 64'(i < 4));
            chk(flags[2] === 1'b0, "R3 empty clear", 64'(flags[2]), 64'd0);
            chk(flags[4] === (i == 7), "R2 full", 64'(flags[4]), 64'(i == 7));
        end
        chk(wr_ready === 1'b0, "R2 wr_ready low when full", 64'(wr_ready), 64'd0);
        chk(flags[1] === 1'b0, "R4 no overflow yet", 64'(flags[1]), 64'd0);
        wr_pair(16'hDEAD, 16'hBEEF);
        chk(flags[1] === 1'b1, "R4 overflow set", 64'(flags[1]), 64'd1);
        chk(flags[4] === 1'b1, "R4 still full", 64'(flags[4]), 64'd1);
        @(negedge clk); enable = 1'b1;
        collect(20);
        exp_w[0] = '0; exp_w[1] = '0;
        for (int i = 0; i < 8; i++) begin
            exp_w[2 + 2*i] = smp(i, 0); exp_w[3 + 2*i] = smp(i, 1);
        end
        exp_w[18] = smp(7, 0); exp_w[19] = smp(7, 1);
        cmp_words("R6 R7 R4 order and drop", 20);
        chk(flags[0] === 1'b1, "R8 underflow after drain", 64'(flags[0]), 64'd1);
        chk(flags[2] === 1'b1, "R3 empty after drain", 64'(flags[2]), 64'd1);
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        chk(flags[1:0] === 2'b00, "R10 sticky flags cleared", 64'(flags[1:0]), 64'd0);
        chk({sclk, ws, sd} === 3'b000, "R10 serial idle", 64'({sclk, ws, sd}), 64'd0);
        @(negedge clk); enable = 1'b1;
        collect(2);
        exp_w[0] = smp(7, 0); exp_w[1] = smp(7, 1);
        cmp_words("R10 holding retained", 2);
        @(negedge clk); enable = 1'b0;
    endtask

    task automatic t_underflow();
        do_reset();
        @(negedge clk); enable = 1'b1;
        fork
            collect(8);
            begin
                repeat (W + 1) @(posedge sclk);
                #1;
                chk(flags[0] === 1'b1, "R8 underflow on empty read", 64'(flags[0]), 64'd1);
                wr_pair(16'hC0DE, 16'h0B1E);
                #1;
                chk(flags[0] === 1'b0, "R9 write clears underflow", 64'(flags[0]), 64'd0);
            end
        join
        for (int k = 0; k < 4; k++) exp_w[k] = '0;
        exp_w[4] = 16'hC0DE; exp_w[5] = 16'h0B1E;
        exp_w[6] = 16'hC0DE; exp_w[7] = 16'h0B1E;
        cmp_words("R8 replay of holding registers", 8);
        chk(flags[0] === 1'b1, "R8 underflow again", 64'(flags[0]), 64'd1);
        @(negedge clk); enable = 1'b0;
    endtask

    task automatic t_collide();
        do_reset();
        @(negedge clk); enable = 1'b1;
        fork
            collect(6);
            begin
                repeat (W) @(posedge sclk);
                @(negedge clk);
                @(negedge clk);
                wr_valid = 1'b1; wr_left = 16'h1F2E; wr_right = 16'h3D4C;
                @(negedge clk);
                wr_valid = 1'b0;
                repeat (2) @(negedge clk);
                chk(flags[0] === 1'b0, "R9 same-cycle write wins", 64'(flags[0]), 64'd0);
            end
        join
        for (int k = 0; k < 4; k++) exp_w[k] = '0;
        exp_w[4] = 16'h1F2E; exp_w[5] = 16'h3D4C;
        cmp_words("R9 collided pair sent next frame", 6);
        @(negedge clk); enable = 1'b0;
    endtask

    task automatic t_cfg();
        realtime t0, t1;
        do_reset();
        @(negedge clk); enable = 1'b1;
        repeat (2) @(posedge sclk);
        t0 = $realtime; @(posedge sclk); t1 = $realtime;
        chk((t1 - t0) == 40.0, "R11 period div=1", 64'(int'(t1 - t0)), 64'd40);
        @(negedge clk); cfg_half_div = DW'(3);
        repeat (2) @(posedge sclk);
        t0 = $realtime; @(posedge sclk); t1 = $realtime;
        chk((t1 - t0) == 40.0, "R11 change ignored while enabled", 64'(int'(t1 - t0)), 64'd40);
        @(negedge clk); enable = 1'b0;
        repeat (2) @(negedge clk); enable = 1'b1;
        repeat (2) @(posedge sclk);
        t0 = $realtime; @(posedge sclk); t1 = $realtime;
        chk((t1 - t0) == 80.0, "R11 period div=3", 64'(int'(t1 - t0)), 64'd80);
        @(negedge clk); enable = 1'b0;
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_underflow();
        t_collide();
        t_cfg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule